// File: doc/BRIEF.md
# DMA Error Status Capture Unit

This unit sits beside a multi-channel DMA engine and records the errors the engine reports. Each report arrives as a one-cycle strobe. It carries a channel number, the pipeline point at which it was raised (channel activation, minor-loop completion, major-loop completion or a bus fault) and an error code. The unit keeps one error bit per channel and a single status record describing the most recent accepted error: the channel, a one-hot flag word naming the error kind, and a valid bit. An interrupt line is raised while any channel whose interrupt enable is set has its error bit set.

Each error kind is legal only at the pipeline point where the engine is allowed to detect it. A plain configuration error belongs to activation. A scatter-gather configuration error belongs to major-loop completion. A channel-link configuration error belongs to minor-loop completion. Bus read and write faults belong to the fault point. An error-cancel may arrive at any point. A strobe whose code does not match its point is discarded. Software retires an error by writing a channel number to the clear port. The status record stays valid until no channel error bit remains.

The status record is driven by a two-state machine. `ST_EMPTY` means no error is held. `ST_HOLD` means a record is held. The transition EMPTY→HOLD is taken on any accepted event. HOLD→HOLD is taken when a new event overwrites the record or when a clear leaves other bits set. HOLD→EMPTY is taken when a clear leaves the channel vector empty and no event arrives in the same cycle. The record is then zeroed.

Top module: `errcap_unit`

## Requirements
- R1: After reset, err_vec, stat_valid, stat_chan, stat_flags and irq are all zero.
- R2: Code 0 (configuration) is accepted only with stage 0 (activation); with any other stage it changes nothing.
- R3: Code 1 (scatter-gather configuration) is accepted only with stage 2 (major-loop completion).
- R4: Code 2 (channel-link configuration) is accepted only with stage 1 (minor-loop completion).
- R5: Codes 3 (bus read fault) and 4 (bus write fault) are accepted only with stage 3 (bus fault).
- R6: An accepted event sets err_vec[ev_chan] one cycle later and, in the same cycle, loads stat_chan=ev_chan, stat_flags=1<<ev_code and stat_valid=1. A later accepted event overwrites the record. A strobe with ev_valid low changes nothing.
- R7: Code 5 (error-cancel) is accepted at every stage and sets stat_flags bit 5 together with the channel and the valid bit.
- R8: Events on consecutive cycles are each accepted; no gap cycle is needed.
- R9: A clear strobe resets err_vec[clr_chan] one cycle later. stat_valid stays 1 while other bits remain set. When no bit remains set and no event is accepted in that cycle, stat_valid, stat_chan and stat_flags return to zero.
- R10: When an accepted event and a clear name the same channel in the same cycle, the bit ends set.
- R11: irq equals the OR of err_vec ANDed with irq_en, and follows irq_en combinationally.
- R12: Codes 6 and 7 are never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Error event strobe |
| ev_chan | input | 4 | Channel of the event |
| ev_stage | input | 2 | Pipeline point: 0 activation, 1 minor loop, 2 major loop, 3 bus fault |
| ev_code | input | 3 | Error code 0..5; 6 and 7 reserved |
| clr_valid | input | 1 | Clear strobe |
| clr_chan | input | 4 | Channel whose error bit is cleared |
| irq_en | input | 16 | Per-channel interrupt enables |
| err_vec | output | 16 | Per-channel error bits |
| stat_valid | output | 1 | Status record holds an error |
| stat_chan | output | 4 | Channel of the latest accepted error |
| stat_flags | output | 6 | One-hot error kind of the latest error |
| irq | output | 1 | Error interrupt |

## Verification
An event or clear presented before a rising edge shows up in err_vec and in the status record right after that edge, one cycle later. irq takes one cycle to follow events and clears, because it is formed from the registered vector. It follows irq_en with no delay. The bench changes inputs 2 ns after each rising edge. It updates its behavioural model at the rising edge and compares every output at the falling edge. Each result is therefore checked in the first cycle it is due, and also in every cycle where it should hold still.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
    typedef enum logic [1:0] {
        STG_ACTIVATE = 2'd0,
        STG_MINOR    = 2'd1,
        STG_MAJOR    = 2'd2,
        STG_FAULT    = 2'd3
    } stage_e;

    typedef enum logic [2:0] {
        EC_CONFIG  = 3'd0,
        EC_SCATTER = 3'd1,
        EC_LINK    = 3'd2,
        EC_BUS_RD  = 3'd3,
        EC_BUS_WR  = 3'd4,
        EC_CANCEL  = 3'd5
    } code_e;

    localparam int NFLAG = 6;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } stat_state_e;
endpackage

// File: rtl/errcap_filter.sv
module errcap_filter
    import errcap_pkg::*;
(
    input  logic             ev_valid,
    input  logic [1:0]       ev_stage,
    input  logic [2:0]       ev_code,
    output logic             accept,
    output logic [NFLAG-1:0] flag_onehot
);
    logic legal;

    // stage legality per error kind (R2..R5, R7, R12)
    always_comb begin
        legal = 1'b0;
        unique case (ev_code)
            EC_CONFIG:  legal = (ev_stage == STG_ACTIVATE);
            EC_SCATTER: legal = (ev_stage == STG_MAJOR);
            EC_LINK:    legal = (ev_stage == STG_MINOR);
            EC_BUS_RD:  legal = (ev_stage == STG_FAULT);
            EC_BUS_WR:  legal = (ev_stage == STG_FAULT);
            EC_CANCEL:  legal = 1'b1;
            default:    legal = 1'b0;
        endcase
    end

    assign accept = ev_valid && legal;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        assign flag_onehot[g] = (ev_code == 3'(g));
    end
endmodule

// File: rtl/errcap_vector.sv
module errcap_vector #(
    parameter int NCH = 16,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [CW-1:0] set_chan,
    input  logic          clr_en,
    input  logic [CW-1:0] clr_chan,
    output logic [NCH-1:0] vec_q,
    output logic          next_zero
);
    logic [NCH-1:0] vec_d;

    for (genvar i = 0; i < NCH; i++) begin : g_bit
        logic set_i;
        logic clr_i;
        assign set_i = set_en && (set_chan == CW'(i));
        assign clr_i = clr_en && (clr_chan == CW'(i));
        // set wins over a same-cycle clear (R10)
        assign vec_d[i] = set_i | (vec_q[i] & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (rst) vec_q <= '0;
        else     vec_q <= vec_d;
    end

    assign next_zero = ~|vec_d;

    a_r6_bit_set: assert property (@(posedge clk) disable iff (rst)
        set_en |=> vec_q[$past(set_chan)]);

    a_r9_bit_cleared: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_chan == clr_chan)) |=> !vec_q[$past(clr_chan)]);
endmodule

// File: rtl/errcap_status.sv
module errcap_status
    import errcap_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [CW-1:0]    chan,
    input  logic [NFLAG-1:0] flags,
    input  logic             vec_next_zero,
    output logic             stat_valid,
    output logic [CW-1:0]    stat_chan,
    output logic [NFLAG-1:0] stat_flags
);
    stat_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_HOLD;
            ST_HOLD:  if (!accept && vec_next_zero) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_chan  <= '0;
            stat_flags <= '0;
        end else if (accept) begin
            stat_chan  <= chan;
            stat_flags <= flags;
        end else if (state_q == ST_HOLD && state_d == ST_EMPTY) begin
            stat_chan  <= '0;
            stat_flags <= '0;
        end
    end

    assign stat_valid = (state_q == ST_HOLD);

    a_r6_record_loaded: assert property (@(posedge clk) disable iff (rst)
        accept |=> (stat_chan == $past(chan)) && (stat_flags == $past(flags)) && stat_valid);

    a_r6_flags_onehot: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $onehot(stat_flags));

    a_r9_empty_is_zero: assert property (@(posedge clk) disable iff (rst)
        !stat_valid |-> (stat_flags == '0) && (stat_chan == '0));
endmodule

// File: rtl/errcap_unit.sv
module errcap_unit
    import errcap_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic [CW-1:0]    ev_chan,
    input  logic [1:0]       ev_stage,
    input  logic [2:0]       ev_code,
    input  logic             clr_valid,
    input  logic [CW-1:0]    clr_chan,
    input  logic [NCH-1:0]   irq_en,
    output logic [NCH-1:0]   err_vec,
    output logic             stat_valid,
    output logic [CW-1:0]    stat_chan,
    output logic [NFLAG-1:0] stat_flags,
    output logic             irq
);
    logic             accept;
    logic [NFLAG-1:0] flag_onehot;
    logic             next_zero;

    errcap_filter u_filter (
        .ev_valid    (ev_valid),
        .ev_stage    (ev_stage),
        .ev_code     (ev_code),
        .accept      (accept),
        .flag_onehot (flag_onehot)
    );

    errcap_vector #(.NCH(NCH)) u_vector (
        .clk       (clk),
        .rst       (rst),
        .set_en    (accept),
        .set_chan  (ev_chan),
        .clr_en    (clr_valid),
        .clr_chan  (clr_chan),
        .vec_q     (err_vec),
        .next_zero (next_zero)
    );

    errcap_status #(.NCH(NCH)) u_status (
        .clk           (clk),
        .rst           (rst),
        .accept        (accept),
        .chan          (ev_chan),
        .flags         (flag_onehot),
        .vec_next_zero (next_zero),
        .stat_valid    (stat_valid),
        .stat_chan     (stat_chan),
        .stat_flags    (stat_flags)
    );

    assign irq = |(err_vec & irq_en);

    a_r9_valid_matches_vec: assert property (@(posedge clk) disable iff (rst)
        stat_valid == (|err_vec));

    a_r7_cancel_flag: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_code == EC_CANCEL) |=> stat_flags[EC_CANCEL] && stat_valid);

    a_r12_reserved_dropped: assert property (@(posedge clk) disable iff (rst)
        (ev_code > 3'd5) |-> !accept);

    always_comb begin
        if (!rst) a_r11_irq_needs_err: assert (!irq || (|err_vec));
    end
endmodule

// File: tb/sim_errcap_unit.sv
module sim_errcap_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_valid = 1'b0;
    logic [3:0]  ev_chan = '0;
    logic [1:0]  ev_stage = '0;
    logic [2:0]  ev_code = '0;
    logic        clr_valid = 1'b0;
    logic [3:0]  clr_chan = '0;
    logic [15:0] irq_en = 16'hA5A5;
    logic [15:0] err_vec;
    logic        stat_valid;
    logic [3:0]  stat_chan;
    logic [5:0]  stat_flags;
    logic        irq;

    errcap_unit u0 (.*);

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit chk_on = 0;
    string tag = "R1";

    logic [15:0] m_vec = '0;
    logic        m_valid = 0;
    logic [3:0]  m_chan = '0;
    logic [5:0]  m_flags = '0;

    function automatic bit legal(input int stg, input int cd);
        case (cd)
            0: return stg == 0;
            1: return stg == 2;
            2: return stg == 1;
            3, 4: return stg == 3;
            5: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        logic [15:0] nv;
        bit acc;
        if (rst) begin
            m_vec = '0; m_valid = 0; m_chan = '0; m_flags = '0;
        end else begin
            acc = ev_valid && legal(int'(ev_stage), int'(ev_code));
            nv = m_vec;
            if (clr_valid) nv[clr_chan] = 1'b0;
            if (acc) nv[ev_chan] = 1'b1;
            if (acc) begin
                m_valid = 1; m_chan = ev_chan; m_flags = 6'b1 << ev_code;
            end else if (nv == '0) begin
                m_valid = 0; m_chan = '0; m_flags = '0;
            end
            m_vec = nv;
        end
    end

    task automatic cmp(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            cmp("err_vec", err_vec, m_vec);
            cmp("stat_valid", 16'(stat_valid), 16'(m_valid));
            cmp("stat_chan", 16'(stat_chan), 16'(m_chan));
            cmp("stat_flags", 16'(stat_flags), 16'(m_flags));
            cmp("irq", 16'(irq), 16'(|(m_vec & irq_en)));
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=<20000", cycles);
            finish_run();
        end
    end

    task automatic drive(input bit v, input int ch, input int stg, input int cd,
                         input bit cv, input int cc);
        @(posedge clk); #2;
        ev_valid = v; ev_chan = 4'(ch); ev_stage = 2'(stg); ev_code = 3'(cd);
        clr_valid = cv; clr_chan = 4'(cc);
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic clear_all();
        for (int c = 0; c < 16; c++) drive(0, 0, 0, 0, 1, c);
        idle();
    endtask

    initial begin
        @(posedge clk); #2; chk_on = 1;
        tag = "R1";                      // reset state
        repeat (2) @(posedge clk);
        #2 rst = 0;
        idle(); idle();

        tag = "R2";                      // configuration error at each stage
        for (int s = 0; s < 4; s++) begin drive(1, 1 + s, s, 0, 0, 0); idle(); end
        clear_all();
        tag = "R3";                      // scatter-gather only at major loop
        for (int s = 0; s < 4; s++) begin drive(1, 5 + s, s, 1, 0, 0); idle(); end
        clear_all();
        tag = "R4";                      // link only at minor loop
        for (int s = 0; s < 4; s++) begin drive(1, 9 + s, s, 2, 0, 0); idle(); end
        clear_all();
        tag = "R5";                      // bus faults only at fault stage
        for (int s = 0; s < 4; s++) begin
            drive(1, 2 + s, s, 3, 0, 0); idle();
            drive(1, 12 + s, s, 4, 0, 0); idle();
        end
        clear_all();
        tag = "R7";                      // cancel at any stage
        for (int s = 0; s < 4; s++) begin drive(1, 3 * s + 1, s, 5, 0, 0); idle(); end
        clear_all();
        tag = "R12";                     // reserved codes
        for (int s = 0; s < 4; s++) begin
            drive(1, s, s, 6, 0, 0); drive(1, s + 4, s, 7, 0, 0);
        end
        idle();
        tag = "R6";                      // strobe low ignored, overwrite
        drive(0, 7, 3, 3, 0, 0); idle();
        drive(1, 7, 3, 3, 0, 0); drive(1, 8, 0, 0, 0, 0); idle();
        clear_all();

        tag = "R8";                      // back-to-back on all channels
        for (int c = 0; c < 16; c++) drive(1, c, 3, 4, 0, 0);
        idle();
        tag = "R11";                     // enables change with bits held
        irq_en = 16'h0000; idle(); irq_en = 16'h8000; idle();
        irq_en = 16'h0001; idle(); irq_en = 16'h0000; idle();
        tag = "R9";                      // clear one by one, valid lasts until empty
        irq_en = 16'hFFFF;
        for (int c = 15; c >= 0; c--) drive(0, 0, 0, 0, 1, c);
        idle(); idle();
        tag = "R11";
        drive(1, 6, 1, 2, 0, 0); irq_en = 16'h0040; idle();
        irq_en = 16'hFFBF; idle();
        tag = "R10";                     // same-cycle set and clear
        drive(1, 6, 0, 0, 1, 6); idle();
        drive(1, 9, 2, 1, 1, 6); idle();   // last bit cleared, new event elsewhere
        drive(0, 0, 0, 0, 1, 9); idle(); idle();
        tag = "R9";
        drive(1, 4, 3, 3, 0, 0); drive(0, 0, 0, 0, 1, 5); idle();
        drive(0, 0, 0, 0, 1, 4); idle(); idle();

        finish_run();
    end
endmodule